// File: doc/BRIEF.md
# Serial Receiver Reset Sequencer

This block drives the reset lines of a serial receiver. After a system reset, and again each time a link restart is requested (for example after a reconfiguration), it asserts the analog front-end reset and the digital datapath reset together. It waits for calibration to finish and holds the analog reset for a minimum time. After releasing the analog reset, it waits until the recovered-clock lock-to-data indication has been high without a break for a minimum time. Only then does it release the digital reset and raise a ready flag.

Lock-to-data can chatter while no data reaches the receiver input. Every sampled low of that status during the lock wait starts the wait over, so the digital reset can only be released after a complete, unbroken window of lock. The minimum times are given in nanoseconds and are converted to clock cycles from a clock-frequency parameter, rounding up. The analog front end, clock recovery and calibration are outside the block.

Top module: `rx_reset_seq`

## Requirements
- R1: While `arst_n` is low, `ana_rst` and `dig_rst` are 1 and `rx_ready` is 0; after reset the sequencer is in its assert phase.
- R2: A `restart_req` sampled high at a clock edge sets `ana_rst` and `dig_rst` to 1 and `rx_ready` to 0 at that same edge, whatever phase the sequence was in.
- R3: `dig_rst` is 1 at every cycle in which `ana_rst` is 1.
- R4: While in the assert phase, each edge that samples `cal_busy` high keeps the sequence in that phase with `ana_rst` high.
- R5: The first edge in the assert phase that samples `cal_busy` low starts the analog hold. `ana_rst` falls exactly ANA_CYC = ceil(MIN_ANA_NS*CLK_MHZ/1000) edges later. With the defaults of 70000 ns, this is 70 µs.
- R6: After `ana_rst` falls, `dig_rst` falls at the edge that samples `cdr_locked` high for the LOCK_CYC-th consecutive time, where LOCK_CYC = ceil(MIN_LOCK_NS*CLK_MHZ/1000). With the defaults of 4000 ns, this is 4 µs.
- R7: Any edge during the lock wait that samples `cdr_locked` low restarts the count, so LOCK_CYC fresh consecutive high samples are needed.
- R8: `rx_ready` rises one edge after `dig_rst` falls. It is never 1 while `dig_rst` is 1.
- R9: `cal_busy` is ignored once the analog hold has begun, and `cdr_locked` is ignored before the lock wait and once ready. A loss of lock after ready does not drop `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_MHZ |
| arst_n | input | 1 | Asynchronous active-low system reset |
| restart_req | input | 1 | Link restart request, sampled each edge |
| cal_busy | input | 1 | Calibration in progress |
| cdr_locked | input | 1 | Clock recovery locked to incoming data |
| ana_rst | output | 1 | Analog front-end reset, active high |
| dig_rst | output | 1 | Digital datapath reset, active high |
| rx_ready | output | 1 | Receiver ready for data |

## Verification
All three outputs are registered. A restart, or a change of phase caused by an input sampled at edge k, shows up on the outputs right after edge k. `ana_rst` falls ANA_CYC edges after the edge that first sees calibration idle. `dig_rst` falls on the edge of the LOCK_CYC-th unbroken lock sample, and `rx_ready` follows one edge later. The bench drives inputs at the falling clock edge and updates a reference model from those inputs at the rising edge. It compares the outputs at the following falling edge, so each result is checked in the exact cycle it is due. Directed cases also measure the restart-to-release, release-to-release and release-to-ready intervals in cycles.

// File: rtl/rx_rst_pkg.sv
`timescale 1ns/1ps
package rx_rst_pkg;

    typedef enum logic [1:0] {
        SEQ_ASSERT   = 2'd0,
        SEQ_HOLD     = 2'd1,
        SEQ_LOCKWAIT = 2'd2,
        SEQ_READY    = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       ana;
        logic       dig;
        logic       rdy;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET_VAL = '{st: SEQ_ASSERT, ana: 1'b1, dig: 1'b1, rdy: 1'b0};

    // Minimum time in ns to whole clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        int unsigned prod;
        int unsigned cyc;
        prod = ns * mhz;
        cyc  = (prod + 999) / 1000;
        return (cyc == 0) ? 1 : cyc;
    endfunction

endpackage

// File: rtl/rx_rst_hold_timer.sv
`timescale 1ns/1ps
module rx_rst_hold_timer #(
    parameter int unsigned CYCLES = 17500
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned CW  = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && (cnt_q == LAST);
        cnt_d = '0;
        if (run && !done) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5: the count never runs past its terminal value
    assert_hold_bound_R5: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/rx_rst_lock_filter.sv
`timescale 1ns/1ps
module rx_rst_lock_filter #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    input  logic lock,
    output logic done
);
    localparam int unsigned CW  = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && lock && (cnt_q == LAST);
        cnt_d = '0;
        if (run && lock && !done) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: a nonzero stability count implies the previous sample was locked
    assert_run_needs_lock_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (cnt_q != '0) |-> $past(lock));

endmodule

// File: rtl/rx_reset_seq.sv
`timescale 1ns/1ps
module rx_reset_seq
    import rx_rst_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 250,
    parameter int unsigned MIN_ANA_NS  = 70000,
    parameter int unsigned MIN_LOCK_NS = 4000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic restart_req,
    input  logic cal_busy,
    input  logic cdr_locked,
    output logic ana_rst,
    output logic dig_rst,
    output logic rx_ready
);
    localparam int unsigned ANA_CYC  = ns_to_cycles(MIN_ANA_NS, CLK_MHZ);
    localparam int unsigned LOCK_CYC = ns_to_cycles(MIN_LOCK_NS, CLK_MHZ);

    seq_regs_t cur_q, nxt_d;
    logic      hold_run, hold_done;
    logic      lock_run, lock_done;

    assign hold_run = (cur_q.st == SEQ_HOLD);
    assign lock_run = (cur_q.st == SEQ_LOCKWAIT);

    rx_rst_hold_timer #(.CYCLES(ANA_CYC)) u_hold (
        .clk    (clk),
        .arst_n (arst_n),
        .run    (hold_run),
        .done   (hold_done)
    );

    rx_rst_lock_filter #(.CYCLES(LOCK_CYC)) u_lock (
        .clk    (clk),
        .arst_n (arst_n),
        .run    (lock_run),
        .lock   (cdr_locked),
        .done   (lock_done)
    );

    always_comb begin
        nxt_d = cur_q;
        if (restart_req) begin
            nxt_d = SEQ_RESET_VAL;
        end else begin
            unique case (cur_q.st)
                SEQ_ASSERT: begin
                    if (!cal_busy) nxt_d.st = SEQ_HOLD;
                end
                SEQ_HOLD: begin
                    if (hold_done) begin
                        nxt_d.st  = SEQ_LOCKWAIT;
                        nxt_d.ana = 1'b0;
                    end
                end
                SEQ_LOCKWAIT: begin
                    if (lock_done) begin
                        nxt_d.st  = SEQ_READY;
                        nxt_d.dig = 1'b0;
                    end
                end
                SEQ_READY: begin
                    nxt_d.rdy = 1'b1;
                end
                default: nxt_d = SEQ_RESET_VAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_q <= SEQ_RESET_VAL;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ana_rst  = cur_q.ana;
    assign dig_rst  = cur_q.dig;
    assign rx_ready = cur_q.rdy;

    assert_restart_resets_R2: assert property (@(posedge clk) disable iff (!arst_n)
        restart_req |=> (ana_rst && dig_rst && !rx_ready));

    assert_dig_covers_ana_R3: assert property (@(posedge clk) disable iff (!arst_n)
        ana_rst |-> dig_rst);

    assert_cal_blocks_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (cur_q.st == SEQ_ASSERT && cal_busy && !restart_req) |=> (cur_q.st == SEQ_ASSERT));

    assert_release_on_lock_R6: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(dig_rst) |-> $past(cdr_locked));

    assert_unlock_delays_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (cur_q.st == SEQ_LOCKWAIT && !cdr_locked) |=> dig_rst);

    assert_ready_after_dig_R8: assert property (@(posedge clk) disable iff (!arst_n)
        rx_ready |-> !dig_rst);

endmodule

// File: tb/rx_reset_seq_test.sv
`timescale 1ns/1ps
module rx_reset_seq_test;

    localparam int MHZ  = 10;
    localparam int ANA  = (70000 * MHZ + 999) / 1000;
    localparam int LOCK = (4000 * MHZ + 999) / 1000;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic restart_req = 1'b0;
    logic cal_busy = 1'b1;
    logic cdr_locked = 1'b0;
    logic ana_rst, dig_rst, rx_ready;

    always #2 clk = ~clk;

    rx_reset_seq #(.CLK_MHZ(MHZ), .MIN_ANA_NS(70000), .MIN_LOCK_NS(4000)) uut (
        .clk(clk), .arst_n(arst_n), .restart_req(restart_req),
        .cal_busy(cal_busy), .cdr_locked(cdr_locked),
        .ana_rst(ana_rst), .dig_rst(dig_rst), .rx_ready(rx_ready)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // reference model: 0 assert, 1 hold, 2 lock wait, 3 ready
    int m_ph = 0, m_hold = 0, m_run = 0;
    bit m_ana = 1, m_dig = 1, m_rdy = 0;

    int cyc = 0;
    int t_ana_fall = -1, t_dig_fall = -1, t_rdy_rise = -1;
    bit p_ana = 1, p_dig = 1, p_rdy = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic void model_update(input bit r, input bit c, input bit l);
        if (r) begin
            m_ph = 0; m_ana = 1; m_dig = 1; m_rdy = 0; m_run = 0;
        end else begin
            case (m_ph)
                0: if (!c) begin m_ph = 1; m_hold = 0; end
                1: begin
                    m_hold++;
                    if (m_hold == ANA) begin m_ph = 2; m_ana = 0; m_run = 0; end
                end
                2: begin
                    m_run = l ? m_run + 1 : 0;
                    if (m_run == LOCK) begin m_ph = 3; m_dig = 0; end
                end
                default: m_rdy = 1;
            endcase
        end
    endfunction

    task automatic step(input bit r, input bit c, input bit l);
        restart_req = r; cal_busy = c; cdr_locked = l;
        @(posedge clk);
        model_update(r, c, l);
        @(negedge clk);
        cyc++;
        chk("R5 ana_rst vs model", ana_rst, m_ana);
        chk("R6 dig_rst vs model", dig_rst, m_dig);
        chk("R8 rx_ready vs model", rx_ready, m_rdy);
        if (ana_rst) chk("R3 dig_rst while ana_rst", dig_rst, 1);
        if (rx_ready) chk("R8 dig_rst while ready", dig_rst, 0);
        if (p_ana && !ana_rst) t_ana_fall = cyc;
        if (p_dig && !dig_rst) t_dig_fall = cyc;
        if (!p_rdy && rx_ready) t_rdy_rise = cyc;
        p_ana = ana_rst; p_dig = dig_rst; p_rdy = rx_ready;
    endtask

    task automatic hold_inputs(input int n, input bit c, input bit l);
        for (int i = 0; i < n; i++) step(1'b0, c, l);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        int t0;
        bit cal_s, lock_good, l;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 ana_rst in reset", ana_rst, 1);
        chk("R1 dig_rst in reset", dig_rst, 1);
        chk("R1 rx_ready in reset", rx_ready, 0);
        arst_n = 1'b1;

        // R4: calibration busy blocks progress
        hold_inputs(200, 1'b1, 1'b1);
        chk("R4 ana_rst held while cal busy", ana_rst, 1);

        // R5 R6 R8: clean sequence timing from a restart
        step(1'b1, 1'b0, 1'b1);
        t0 = cyc;
        hold_inputs(ANA + LOCK + 10, 1'b0, 1'b1);
        chk("R5 restart to ana release", t_ana_fall - t0, ANA + 1);
        chk("R6 ana release to dig release", t_dig_fall - t_ana_fall, LOCK);
        chk("R8 dig release to ready", t_rdy_rise - t_dig_fall, 1);

        // R9: loss of lock after ready is ignored
        hold_inputs(50, 1'b1, 1'b0);
        chk("R9 ready kept without lock", rx_ready, 1);

        // R7 R9: cal toggles during hold ignored; glitch one short of window
        step(1'b1, 1'b0, 1'b0);
        t0 = cyc;
        step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < ANA; i++) step(1'b0, i[3], 1'b0);
        chk("R9 cal ignored in hold", t_ana_fall - t0, ANA + 1);
        hold_inputs(LOCK - 1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        hold_inputs(LOCK - 1, 1'b0, 1'b1);
        chk("R7 glitch restarts wait", dig_rst, 1);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 release after fresh window", dig_rst, 0);

        // R2: restart in the middle of the lock wait
        step(1'b1, 1'b0, 1'b1);
        hold_inputs(ANA + 5, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        chk("R2 ana_rst after mid restart", ana_rst, 1);
        chk("R2 ready low after mid restart", rx_ready, 0);

        // random phase
        cal_s = 0; lock_good = 1;
        for (int k = 0; k < 60000; k++) begin
            if ($urandom % 300 == 0) cal_s = ~cal_s;
            if ($urandom % 2000 == 0) lock_good = ~lock_good;
            l = lock_good ? ($urandom % 200 != 0) : bit'($urandom % 2);
            step(($urandom % 4000) == 0, cal_s, l);
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule